// File: doc/BRIEF.md
# Microwire Host Register Bank

This block is the processor-facing half of a Microwire serial-memory master. A processor reaches six byte-wide registers through a select-gated port with separate read and write strobes and a 16-bit address. It loads a memory address and a 16-bit word, then writes a 3-bit command code with a start bit into the control register. The block turns that code into the opcode and address pattern the serial engine shifts out and issues a single request. It then waits for the engine's completion, keeps any word the engine returns and raises a level interrupt. Reading the status register clears the sticky bits, which drops the interrupt.

A small sequencer runs the command path. It has three states. ST_IDLE waits for a launch. On an accepted launch (start bit set, legal code, not busy) it goes to ST_ISSUE. ST_ISSUE drives the one-cycle request and always moves on to ST_WAIT. ST_WAIT returns to ST_IDLE on the engine's done pulse. Serial bit timing is handled by the engine and is not part of this block.

Top module: `mw_host_regs`

## Requirements
- R1: After reset, hif_rdata, hif_irq, eng_req, eng_op, eng_addr and eng_wdata are all zero, and the status register reads 0x00.
- R2: A write with hif_sel_n low and hif_wr_en high stores hif_wdata from the next cycle on. The writable registers are: control at 0x0000 (bits [2:0] hold the code and read back; bit 7 is the start bit and reads as 0), memory address at 0x0001, word low byte at 0x0002 and word high byte at 0x0003. A write with hif_sel_n high changes nothing.
- R3: A read with hif_sel_n low and hif_rd_en high places the addressed register's value on hif_rdata for exactly one cycle. That cycle follows the RD_LAT-th rising edge, counting the edge that samples the strobe. At all other times hif_rdata is zero.
- R4: Address 0x0007 returns REV_ID and ignores writes. Any address outside 0x0000 to 0x0007, including those with nonzero upper bits, reads 0 and ignores writes.
- R5: A control write with bit 7 set and a legal code, made while idle, raises eng_req for exactly one cycle right after the write edge. Status bit 1 (busy) stays set from then until the engine's done pulse is taken.
- R6: Code translation to {eng_op, eng_addr}. 000 read gives 2'b10 with the stored address. 001 write gives 2'b01 with the stored address. 100 erase gives 2'b11 with the stored address. 010 fill gives 2'b00 with 0x40. 011 wipe-all gives 2'b00 with 0x80. 101 unlock gives 2'b00 with 0xC0. 110 lock gives 2'b00 with 0x00. eng_wdata is {high byte, low byte} as stored at launch.
- R7: A start write with code 111, or any start write while busy, issues no request, leaves eng_op, eng_addr and eng_wdata unchanged, and sets status bit 2 (error).
- R8: A done pulse in ST_WAIT sets status bit 0 (done) and clears busy. For a read command it also stores eng_rdata at 0x0005 (low byte) and 0x0006 (high byte) and sets status bit 3 (read word valid). A done pulse at any other time has no effect.
- R9: hif_irq is high whenever done or error is pending. A read of status at 0x0004 returns the value from before the read and clears done and error. An event that lands in the same cycle as the read stays pending.
- R10: Status bit 3 clears when a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hif_sel_n | input | 1 | Active-low register select |
| hif_rd_en | input | 1 | Register read strobe |
| hif_wr_en | input | 1 | Register write strobe |
| hif_addr | input | 16 | Register address |
| hif_wdata | input | 8 | Register write data |
| hif_rdata | output | 8 | Register read data, delayed RD_LAT cycles |
| hif_irq | output | 1 | Level interrupt: done or error pending |
| eng_req | output | 1 | One-cycle request to the serial engine |
| eng_op | output | 2 | Microwire opcode for the request |
| eng_addr | output | 8 | Address field for the request |
| eng_wdata | output | 16 | Data word for write-type requests |
| eng_done | input | 1 | Engine completion pulse |
| eng_rdata | input | 16 | Word returned by the engine with done |

## Verification
The hardest case to reach from the ports is a status read sampled on the same edge as the engine's done pulse. The pending bit must survive the clear while the returned byte still shows it as busy. The bench drives the select, read strobe, status address and the done pulse together on one falling edge while a command waits. It then checks that the interrupt stays up and that the next status read shows only done. It also starts a new command while one is still in flight, to check that the engine fields hold and only the error bit moves.

// File: rtl/mw_host_pkg.sv
package mw_host_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        CMD_READ     = 3'd0,
        CMD_WRITE    = 3'd1,
        CMD_FILL     = 3'd2,
        CMD_WIPE_ALL = 3'd3,
        CMD_ERASE    = 3'd4,
        CMD_UNLOCK   = 3'd5,
        CMD_LOCK     = 3'd6,
        CMD_ILLEGAL  = 3'd7
    } host_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [1:0]        op;
        logic [BYTE_W-1:0] addr;
        logic              is_read;
    } wire_cmd_t;

    localparam logic [15:0] OFS_CTRL   = 16'h0000;
    localparam logic [15:0] OFS_MADDR  = 16'h0001;
    localparam logic [15:0] OFS_WLO    = 16'h0002;
    localparam logic [15:0] OFS_WHI    = 16'h0003;
    localparam logic [15:0] OFS_STAT   = 16'h0004;
    localparam logic [15:0] OFS_RLO    = 16'h0005;
    localparam logic [15:0] OFS_RHI    = 16'h0006;
    localparam logic [15:0] OFS_REV    = 16'h0007;

    function automatic wire_cmd_t map_cmd(host_cmd_e c, logic [BYTE_W-1:0] a);
        wire_cmd_t r;
        r = '{op: 2'b00, addr: '0, is_read: 1'b0};
        unique case (c)
            CMD_READ:     begin r.op = 2'b10; r.addr = a; r.is_read = 1'b1; end
            CMD_WRITE:    begin r.op = 2'b01; r.addr = a; end
            CMD_ERASE:    begin r.op = 2'b11; r.addr = a; end
            CMD_FILL:     r.addr = 8'h40;
            CMD_WIPE_ALL: r.addr = 8'h80;
            CMD_UNLOCK:   r.addr = 8'hC0;
            CMD_LOCK:     r.addr = 8'h00;
            default:      r.addr = 8'h00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mw_rd_pipe.sv
module mw_rd_pipe #(
    parameter int LAT = 2,
    parameter int W   = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [W-1:0] value,
    output logic [W-1:0] data
);

    logic [W-1:0] stg [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) stg[i] <= '0;
        end else begin
            stg[0] <= fire ? value : '0;
            for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
        end
    end

    assign data = stg[LAT-1];

endmodule

// File: rtl/mw_cmd_fsm.sv
module mw_cmd_fsm
    import mw_host_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic [CODE_W-1:0]   code,
    input  logic [BYTE_W-1:0]   mem_addr,
    input  logic [WORD_W-1:0]   word,
    input  logic                eng_done,
    output logic                busy,
    output logic                accepted,
    output logic                done_evt,
    output logic                err_evt,
    output logic                cur_read,
    output logic                eng_req,
    output logic [1:0]          eng_op,
    output logic [BYTE_W-1:0]   eng_addr,
    output logic [WORD_W-1:0]   eng_wdata
);

    seq_state_e state_q, state_d;
    wire_cmd_t  mapped;
    logic       bad_code;

    assign bad_code = (code == CMD_ILLEGAL);
    assign mapped   = map_cmd(host_cmd_e'(code), mem_addr);
    assign accepted = launch && !bad_code && (state_q == ST_IDLE);
    assign err_evt  = launch && (bad_code || (state_q != ST_IDLE));
    assign done_evt = (state_q == ST_WAIT) && eng_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accepted) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (eng_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        eng_req = (state_q == ST_ISSUE);
        busy    = (state_q != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_op    <= '0;
            eng_addr  <= '0;
            eng_wdata <= '0;
            cur_read  <= 1'b0;
        end else if (accepted) begin
            eng_op    <= mapped.op;
            eng_addr  <= mapped.addr;
            eng_wdata <= word;
            cur_read  <= mapped.is_read;
        end
    end

    AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req); // R5
    AST_BAD_CODE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && bad_code) |=> !eng_req); // R7
    AST_FIELDS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(eng_op) && $stable(eng_addr) && $stable(eng_wdata))); // R7

endmodule

// File: rtl/mw_host_regs.sv
module mw_host_regs
    import mw_host_pkg::*;
#(
    parameter int          RD_LAT = 2,
    parameter int          HIF_AW = 16,
    parameter logic [7:0]  REV_ID = 8'h21
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hif_sel_n,
    input  logic                hif_rd_en,
    input  logic                hif_wr_en,
    input  logic [HIF_AW-1:0]   hif_addr,
    input  logic [BYTE_W-1:0]   hif_wdata,
    output logic [BYTE_W-1:0]   hif_rdata,
    output logic                hif_irq,
    output logic                eng_req,
    output logic [1:0]          eng_op,
    output logic [BYTE_W-1:0]   eng_addr,
    output logic [WORD_W-1:0]   eng_wdata,
    input  logic                eng_done,
    input  logic [WORD_W-1:0]   eng_rdata
);

    logic                rd_fire, wr_fire, launch, stat_rd;
    logic [CODE_W-1:0]   ctrl_code;
    logic [BYTE_W-1:0]   maddr_q, wlo_q, whi_q, rlo_q, rhi_q, rd_mux;
    logic                done_q, err_q, rxv_q;
    logic                busy, accepted, done_evt, err_evt, cur_read;

    assign rd_fire = !hif_sel_n && hif_rd_en;
    assign wr_fire = !hif_sel_n && hif_wr_en;
    assign launch  = wr_fire && (hif_addr == HIF_AW'(OFS_CTRL)) && hif_wdata[BYTE_W-1];
    assign stat_rd = rd_fire && (hif_addr == HIF_AW'(OFS_STAT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_code <= '0;
            maddr_q   <= '0;
            wlo_q     <= '0;
            whi_q     <= '0;
        end else if (wr_fire) begin
            unique case (hif_addr)
                HIF_AW'(OFS_CTRL):  ctrl_code <= hif_wdata[CODE_W-1:0];
                HIF_AW'(OFS_MADDR): maddr_q   <= hif_wdata;
                HIF_AW'(OFS_WLO):   wlo_q     <= hif_wdata;
                HIF_AW'(OFS_WHI):   whi_q     <= hif_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            rxv_q  <= 1'b0;
            rlo_q  <= '0;
            rhi_q  <= '0;
        end else begin
            done_q <= done_evt || (done_q && !stat_rd);
            err_q  <= err_evt  || (err_q  && !stat_rd);
            if (accepted)
                rxv_q <= 1'b0;
            else if (done_evt && cur_read)
                rxv_q <= 1'b1;
            if (done_evt && cur_read) begin
                rlo_q <= eng_rdata[BYTE_W-1:0];
                rhi_q <= eng_rdata[WORD_W-1:BYTE_W];
            end
        end
    end

    always_comb begin
        unique case (hif_addr)
            HIF_AW'(OFS_CTRL):  rd_mux = {{(BYTE_W-CODE_W){1'b0}}, ctrl_code};
            HIF_AW'(OFS_MADDR): rd_mux = maddr_q;
            HIF_AW'(OFS_WLO):   rd_mux = wlo_q;
            HIF_AW'(OFS_WHI):   rd_mux = whi_q;
            HIF_AW'(OFS_STAT):  rd_mux = {4'b0, rxv_q, err_q, busy, done_q};
            HIF_AW'(OFS_RLO):   rd_mux = rlo_q;
            HIF_AW'(OFS_RHI):   rd_mux = rhi_q;
            HIF_AW'(OFS_REV):   rd_mux = REV_ID;
            default:            rd_mux = '0;
        endcase
    end

    assign hif_irq = done_q || err_q;

    mw_rd_pipe #(.LAT(RD_LAT), .W(BYTE_W)) u_rd_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (rd_fire),
        .value (rd_mux),
        .data  (hif_rdata)
    );

    mw_cmd_fsm u_cmd_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .code      (hif_wdata[CODE_W-1:0]),
        .mem_addr  (maddr_q),
        .word      ({whi_q, wlo_q}),
        .eng_done  (eng_done),
        .busy      (busy),
        .accepted  (accepted),
        .done_evt  (done_evt),
        .err_evt   (err_evt),
        .cur_read  (cur_read),
        .eng_req   (eng_req),
        .eng_op    (eng_op),
        .eng_addr  (eng_addr),
        .eng_wdata (eng_wdata)
    );

    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> hif_irq); // R8
    AST_STATUS_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !done_evt && !err_evt) |=> !hif_irq); // R9
    AST_NEW_CMD_CLEARS_RXV: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> !rxv_q); // R10

endmodule

// File: tb/mw_host_regs_tb.sv
module mw_host_regs_tb_top;

    localparam int         CLK_PERIOD = 10;
    localparam int         LAT        = 2;
    localparam logic [7:0] REV        = 8'h21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hif_sel_n = 1'b1, hif_rd_en = 1'b0, hif_wr_en = 1'b0;
    logic [15:0] hif_addr = '0;
    logic [7:0]  hif_wdata = '0;
    logic [7:0]  hif_rdata;
    logic        hif_irq, eng_req;
    logic [1:0]  eng_op;
    logic [7:0]  eng_addr;
    logic [15:0] eng_wdata;
    logic        eng_done = 1'b0;
    logic [15:0] eng_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit run_cmp = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_host_regs #(.RD_LAT(LAT), .HIF_AW(16), .REV_ID(REV)) dut_i (
        .clk(clk), .rst_n(rst_n), .hif_sel_n(hif_sel_n), .hif_rd_en(hif_rd_en),
        .hif_wr_en(hif_wr_en), .hif_addr(hif_addr), .hif_wdata(hif_wdata),
        .hif_rdata(hif_rdata), .hif_irq(hif_irq), .eng_req(eng_req), .eng_op(eng_op),
        .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_rdata(eng_rdata)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_q[$];
    int          m_st;          // 0 idle, 1 issuing, 2 waiting
    logic [2:0]  m_ctrl;
    logic [7:0]  m_ma, m_lo, m_hi, m_rlo, m_rhi, m_rdata;
    logic        m_done, m_err, m_rxv, m_isrd, m_req;
    logic [1:0]  m_op;
    logic [7:0]  m_ea;
    logic [15:0] m_wd;

    function automatic logic [1:0] ref_op(input logic [2:0] c);
        case (c)
            3'd0: return 2'b10;
            3'd1: return 2'b01;
            3'd4: return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [7:0] ref_addr(input logic [2:0] c, input logic [7:0] a);
        case (c)
            3'd0, 3'd1, 3'd4: return a;
            3'd2: return 8'h40;
            3'd3: return 8'h80;
            3'd5: return 8'hC0;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] m_read(input logic [15:0] a);
        case (a)
            16'h0000: return {5'b0, m_ctrl};
            16'h0001: return m_ma;
            16'h0002: return m_lo;
            16'h0003: return m_hi;
            16'h0004: return {4'b0, m_rxv, m_err, (m_st != 0), m_done};
            16'h0005: return m_rlo;
            16'h0006: return m_rhi;
            16'h0007: return REV;
            default:  return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            for (int i = 0; i < LAT-1; i++) m_q.push_back(8'h00);
            m_st = 0; m_ctrl = 0; m_ma = 0; m_lo = 0; m_hi = 0; m_rlo = 0; m_rhi = 0;
            m_rdata = 0; m_done = 0; m_err = 0; m_rxv = 0; m_isrd = 0; m_req = 0;
            m_op = 0; m_ea = 0; m_wd = 0;
        end else begin
            logic rd, wr, dne, lw, bad, good, clr;
            int nst;
            rd   = !hif_sel_n && hif_rd_en;
            wr   = !hif_sel_n && hif_wr_en;
            m_q.push_back(rd ? m_read(hif_addr) : 8'h00);
            m_rdata = m_q.pop_front();
            dne  = (m_st == 2) && eng_done;
            lw   = wr && hif_addr == 16'h0000 && hif_wdata[7];
            bad  = lw && (hif_wdata[2:0] == 3'd7 || m_st != 0);
            good = lw && !bad;
            clr  = rd && hif_addr == 16'h0004;
            m_done = (m_done && !clr) || dne;
            m_err  = (m_err && !clr) || bad;
            if (dne && m_isrd) begin m_rlo = eng_rdata[7:0]; m_rhi = eng_rdata[15:8]; end
            if (good) m_rxv = 0; else if (dne && m_isrd) m_rxv = 1;
            if (good) begin
                m_op = ref_op(hif_wdata[2:0]);
                m_ea = ref_addr(hif_wdata[2:0], m_ma);
                m_wd = {m_hi, m_lo};
                m_isrd = (hif_wdata[2:0] == 3'd0);
            end
            if (wr) case (hif_addr)
                16'h0000: m_ctrl = hif_wdata[2:0];
                16'h0001: m_ma = hif_wdata;
                16'h0002: m_lo = hif_wdata;
                16'h0003: m_hi = hif_wdata;
                default: ;
            endcase
            nst = m_st;
            if (m_st == 0 && good) nst = 1;
            else if (m_st == 1) nst = 2;
            else if (m_st == 2 && eng_done) nst = 0;
            m_st  = nst;
            m_req = (m_st == 1);
        end
    end

    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            chk({8'h0, hif_rdata}, {8'h0, m_rdata}, "R3 model read data");
            chk({15'h0, hif_irq}, {15'h0, (m_done || m_err)}, "R9 model irq");
            chk({15'h0, eng_req}, {15'h0, m_req}, "R5 model request");
            chk({6'h0, eng_op, eng_addr}, {6'h0, m_op, m_ea}, "R6 model op/addr");
            chk(eng_wdata, m_wd, "R6 model word");
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input bit sel = 1'b1);
        @(negedge clk);
        hif_sel_n = !sel; hif_wr_en = 1'b1; hif_addr = a; hif_wdata = d;
        @(negedge clk);
        hif_sel_n = 1'b1; hif_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        hif_sel_n = 1'b0; hif_rd_en = 1'b1; hif_addr = a;
        @(negedge clk);
        hif_sel_n = 1'b1; hif_rd_en = 1'b0;
        repeat (LAT-1) @(negedge clk);
        d = hif_rdata;
    endtask

    task automatic finish_cmd(input logic [15:0] w);
        @(negedge clk);
        eng_done = 1'b1; eng_rdata = w;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // ---------------- scenario ----------------
    initial begin
        logic [7:0] v;
        logic [2:0] codes [6];
        codes = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk({8'h0, hif_rdata}, 16'h0, "R1 rdata at reset");
        chk({15'h0, hif_irq}, 16'h0, "R1 irq at reset");
        chk({15'h0, eng_req}, 16'h0, "R1 req at reset");
        chk({6'h0, eng_op, eng_addr}, 16'h0, "R1 op/addr at reset");
        chk(eng_wdata, 16'h0, "R1 word at reset");
        run_cmp = 1'b1;
        bus_read(16'h0004, v); chk({8'h0, v}, 16'h00, "R1 status at reset");

        // R2 register storage and select gating
        bus_write(16'h0001, 8'h5A);
        bus_write(16'h0002, 8'h34);
        bus_write(16'h0003, 8'h12);
        bus_read(16'h0001, v); chk({8'h0, v}, 16'h5A, "R2 address reg");
        bus_read(16'h0002, v); chk({8'h0, v}, 16'h34, "R2 word low");
        bus_read(16'h0003, v); chk({8'h0, v}, 16'h12, "R2 word high");
        bus_write(16'h0001, 8'hFF, 1'b0);
        bus_read(16'h0001, v); chk({8'h0, v}, 16'h5A, "R2 write without select");
        bus_write(16'h0000, 8'h05);
        chk({15'h0, eng_req}, 16'h0, "R5 no start bit no request");
        bus_read(16'h0000, v); chk({8'h0, v}, 16'h05, "R2 control code readback");

        // R4 revision and unmapped space
        bus_read(16'h0007, v); chk({8'h0, v}, {8'h0, REV}, "R4 revision");
        bus_write(16'h0007, 8'h00);
        bus_read(16'h0007, v); chk({8'h0, v}, {8'h0, REV}, "R4 revision write ignored");
        bus_write(16'h0101, 8'h77);
        bus_read(16'h0001, v); chk({8'h0, v}, 16'h5A, "R4 unmapped write ignored");
        bus_read(16'h0100, v); chk({8'h0, v}, 16'h00, "R4 unmapped read zero");

        // R8 done while idle ignored
        finish_cmd(16'hAAAA);
        chk({15'h0, hif_irq}, 16'h0, "R8 idle done ignored");

        // R5 R6 R8 read command
        bus_write(16'h0000, 8'h80);
        chk({15'h0, eng_req}, 16'h1, "R5 request pulse");
        chk({6'h0, eng_op, eng_addr}, {6'h0, 2'b10, 8'h5A}, "R6 read translation");
        @(negedge clk);
        chk({15'h0, eng_req}, 16'h0, "R5 request single cycle");
        bus_read(16'h0004, v); chk({8'h0, v}, 16'h02, "R5 busy while waiting");
        finish_cmd(16'hBEEF);
        chk({15'h0, hif_irq}, 16'h1, "R8 irq after done");
        bus_read(16'h0004, v); chk({8'h0, v}, 16'h09, "R8 done and word valid");
        chk({15'h0, hif_irq}, 16'h0, "R9 irq cleared by status read");
        bus_read(16'h0005, v); chk({8'h0, v}, 16'hEF, "R8 returned low byte");
        bus_read(16'h0006, v); chk({8'h0, v}, 16'hBE, "R8 returned high byte");

        // R7 R10 launch while busy
        bus_write(16'h0000, 8'h82);
        chk({6'h0, eng_op, eng_addr}, {6'h0, 2'b00, 8'h40}, "R6 fill translation");
        chk(eng_wdata, 16'h1234, "R6 word at launch");
        bus_write(16'h0000, 8'h85);
        chk({6'h0, eng_op, eng_addr}, {6'h0, 2'b00, 8'h40}, "R7 fields held while busy");
        chk({15'h0, hif_irq}, 16'h1, "R7 error raises irq");
        bus_read(16'h0004, v); chk({8'h0, v}, 16'h06, "R7 R10 busy+error, word valid cleared");
        finish_cmd(16'h0000);
        bus_read(16'h0004, v); chk({8'h0, v}, 16'h01, "R8 done after fill");

        // R6 every remaining code
        foreach (codes[k]) begin
            bus_write(16'h0000, {5'b10000, codes[k]});
            chk({6'h0, eng_op, eng_addr}, {6'h0, ref_op(codes[k]), ref_addr(codes[k], 8'h5A)},
                "R6 code translation");
            finish_cmd(16'h0000);
            bus_read(16'h0004, v); chk({8'h0, v}, 16'h01, "R8 done per code");
        end

        // R7 illegal code
        bus_write(16'h0000, 8'h87);
        chk({15'h0, eng_req}, 16'h0, "R7 illegal code no request");
        bus_read(16'h0004, v); chk({8'h0, v}, 16'h04, "R7 error bit");

        // R9 status read in the same cycle as done
        bus_write(16'h0000, 8'h81);
        @(negedge clk);
        @(negedge clk);
        hif_sel_n = 1'b0; hif_rd_en = 1'b1; hif_addr = 16'h0004; eng_done = 1'b1;
        @(negedge clk);
        hif_sel_n = 1'b1; hif_rd_en = 1'b0; eng_done = 1'b0;
        repeat (LAT-1) @(negedge clk);
        chk({8'h0, hif_rdata}, 16'h02, "R9 pre-clear status value");
        chk({15'h0, hif_irq}, 16'h1, "R9 same-cycle done stays pending");
        bus_read(16'h0004, v); chk({8'h0, v}, 16'h01, "R9 done kept through clear");

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule